// File: doc/BRIEF.md
# Integer Lifting Three-Term Compute Core

This block computes one step of an integer lifting wavelet transform. Each step takes a middle data word and two outer data words. Each outer word is weighted by a small signed coefficient, the weighted terms are summed, and the sum is added to the middle word. The coefficients are stored as integers that carry a fixed scale of sixteen. The core removes that scale with a hardwired arithmetic shift and rounds to nearest, so integer inputs give integer outputs.

A sequencer presents the operands together with a strobe. The core returns a registered result one clock later. Some lifting steps need only one product. For those steps a mode input switches off the second multiplier and forces its operands to constant zero, which cuts switching activity.

The output word keeps the data width instead of growing. A result that would fall outside the signed range is clamped to the nearest limit, and a separate overflow flag reports it.

Top module: `lift_step_core`

## Requirements
- R1: Data inputs and the result are 10-bit two's-complement words. Each coefficient is a 6-bit two's-complement word equal to the real coefficient times 16. The extreme operands (-512 data, -32 coefficients) are handled without internal wrap.
- R2: With `one_mul_i`=0 the true value is mid + floor((a*ca + b*cb + 8) / 16): products at full width, one rounding offset of 8, then an arithmetic shift right by 4.
- R3: With `one_mul_i`=1 the true value is mid + floor((a*ca + 8) / 16), and `b_i` and `cb_i` have no effect on `res_o` or `ovf_o`.
- R4: If the true value is above 511, `res_o`=511 and `ovf_o`=1. If it is below -512, `res_o`=-512 and `ovf_o`=1.
- R5: If the true value lies in [-512, 511], `res_o` equals it and `ovf_o`=0, including at both limits.
- R6: `vld_o` is 1 in exactly the cycle after a cycle with `stb_i`=1, and `res_o`/`ovf_o` carry that operand set's result in the same cycle.
- R7: In a cycle after `stb_i`=0, `vld_o`=0 and `res_o`/`ovf_o` keep their previous values.
- R8: While `rst_ni`=0 (asynchronous, active low), `res_o`=0, `ovf_o`=0 and `vld_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Operands valid this cycle |
| one_mul_i | input | 1 | 1 = single-product step, second multiplier off |
| mid_i | input | 10 | Middle data word, added without weighting |
| a_i | input | 10 | First outer data word |
| b_i | input | 10 | Second outer data word |
| ca_i | input | 6 | Coefficient for `a_i`, scaled by 16 |
| cb_i | input | 6 | Coefficient for `b_i`, scaled by 16 |
| res_o | output | 10 | Registered saturated result |
| ovf_o | output | 1 | Result was clamped |
| vld_o | output | 1 | Result updated this cycle |

## Verification
The only state is the output register. A wrong value there therefore shows at the ports in the cycle right after the strobe that produced it. A wrong rounding offset, sign extension or gating shows as a result that is off by one or more on operand sets chosen to straddle the rounding boundaries. A wrong clamp shows as a wrapped value, or as a flag that disagrees with the result, on operands driven just past either limit. A fault in the hold path shows in the idle cycles that follow, because the value changes while no strobe is present.

// File: rtl/lift_pkg.sv
package lift_pkg;
    localparam int LIFT_DATA_W   = 10;
    localparam int LIFT_COEF_W   = 6;
    localparam int LIFT_SCALE_SH = 4;

    typedef enum logic {
        STEP_DUAL   = 1'b0,
        STEP_SINGLE = 1'b1
    } step_mode_e;
endpackage

// File: rtl/lift_mult.sv
module lift_mult #(
    parameter int DATA_W = 10,
    parameter int COEF_W = 6,
    localparam int PROD_W = DATA_W + COEF_W
) (
    input  logic                     en_i,
    input  logic signed [DATA_W-1:0] x_i,
    input  logic signed [COEF_W-1:0] c_i,
    output logic signed [PROD_W-1:0] p_o
);
    logic signed [DATA_W-1:0] x_gated;
    logic signed [COEF_W-1:0] c_gated;

    // operand isolation: a disabled multiplier sees constant zeros
    always_comb begin
        x_gated = en_i ? x_i : '0;
        c_gated = en_i ? c_i : '0;
        p_o     = PROD_W'(x_gated) * PROD_W'(c_gated);
    end
endmodule

// File: rtl/lift_round_shift.sv
module lift_round_shift #(
    parameter int W  = 19,
    parameter int SH = 4
) (
    input  logic signed [W-1:0] sum_i,
    output logic signed [W-1:0] q_o
);
    localparam logic signed [W-1:0] HALF = W'(1) << (SH - 1);

    always_comb begin
        q_o = (sum_i + HALF) >>> SH;
    end
endmodule

// File: rtl/lift_sat.sv
module lift_sat #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 10
) (
    input  logic signed [IN_W-1:0]  v_i,
    output logic signed [OUT_W-1:0] v_o,
    output logic                    clip_o
);
    localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    always_comb begin
        clip_o = 1'b1;
        if (v_i > HI) begin
            v_o = OUT_W'(HI);
        end else if (v_i < LO) begin
            v_o = OUT_W'(LO);
        end else begin
            v_o    = OUT_W'(v_i);
            clip_o = 1'b0;
        end
    end
endmodule

// File: rtl/lift_step_core.sv
module lift_step_core #(
    parameter int DATA_W   = lift_pkg::LIFT_DATA_W,
    parameter int COEF_W   = lift_pkg::LIFT_COEF_W,
    parameter int SCALE_SH = lift_pkg::LIFT_SCALE_SH
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     stb_i,
    input  logic                     one_mul_i,
    input  logic signed [DATA_W-1:0] mid_i,
    input  logic signed [DATA_W-1:0] a_i,
    input  logic signed [DATA_W-1:0] b_i,
    input  logic signed [COEF_W-1:0] ca_i,
    input  logic signed [COEF_W-1:0] cb_i,
    output logic signed [DATA_W-1:0] res_o,
    output logic                     ovf_o,
    output logic                     vld_o
);
    import lift_pkg::*;

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int WIDE_W = PROD_W + 3;
    localparam int N_MUL  = 2;

    typedef struct packed {
        logic signed [DATA_W-1:0] res;
        logic                     ovf;
        logic                     vld;
    } out_state_t;

    step_mode_e mode;
    assign mode = step_mode_e'(one_mul_i);

    logic signed [DATA_W-1:0] xs  [N_MUL];
    logic signed [COEF_W-1:0] cs  [N_MUL];
    logic                     ens [N_MUL];
    logic signed [PROD_W-1:0] ps  [N_MUL];

    assign xs[0]  = a_i;
    assign cs[0]  = ca_i;
    assign ens[0] = 1'b1;
    assign xs[1]  = b_i;
    assign cs[1]  = cb_i;
    assign ens[1] = (mode == STEP_DUAL);

    for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        lift_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
            .en_i (ens[g]),
            .x_i  (xs[g]),
            .c_i  (cs[g]),
            .p_o  (ps[g])
        );
    end

    logic signed [WIDE_W-1:0] prod_sum;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] total;
    logic signed [DATA_W-1:0] clamped;
    logic                     clipped;

    always_comb begin
        prod_sum = WIDE_W'(ps[0]) + WIDE_W'(ps[1]);
    end

    lift_round_shift #(.W(WIDE_W), .SH(SCALE_SH)) u_rnd (
        .sum_i (prod_sum),
        .q_o   (scaled)
    );

    always_comb begin
        total = scaled + WIDE_W'(mid_i);
    end

    lift_sat #(.IN_W(WIDE_W), .OUT_W(DATA_W)) u_sat (
        .v_i    (total),
        .v_o    (clamped),
        .clip_o (clipped)
    );

    out_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = stb_i;
        if (stb_i) begin
            st_d.res = clamped;
            st_d.ovf = clipped;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign ovf_o = st_q.ovf;
    assign vld_o = st_q.vld;

    localparam logic signed [DATA_W-1:0] RES_HI = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] RES_LO = {1'b1, {(DATA_W-1){1'b0}}};

    // R6: a strobe yields a valid result in the following cycle
    a_r6_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i |=> vld_o);
    // R7: no valid without a strobe
    a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb_i |=> !vld_o);
    // R7: result and flag hold while idle
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb_i |=> ($stable(res_o) && $stable(ovf_o)));
    // R4: a raised flag always comes with a limit value
    a_r4_ovf_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (res_o == RES_HI || res_o == RES_LO));
endmodule

// File: tb/sim_lift_step_core.sv
module sim_lift_step_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic one_mul = 1'b0;
    logic signed [9:0] mid = '0, a = '0, b = '0;
    logic signed [5:0] ca = '0, cb = '0;
    logic signed [9:0] res;
    logic ovf, vld;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lift_step_core u0 (
        .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .one_mul_i(one_mul),
        .mid_i(mid), .a_i(a), .b_i(b), .ca_i(ca), .cb_i(cb),
        .res_o(res), .ovf_o(ovf), .vld_o(vld)
    );

    // behavioural reference, updated on every clock
    int    exp_res = 0;
    bit    exp_ovf = 0;
    bit    exp_vld = 0;
    string exp_tag = "R8";
    string cur_tag = "R2";

    function automatic int floor_div16(int v);
        int q;
        q = v / 16;
        if ((v % 16) != 0 && v < 0) q = q - 1;
        return q;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_res = 0; exp_ovf = 0; exp_vld = 0; exp_tag = "R8";
        end else begin
            exp_vld = stb;
            if (stb) begin
                int p, t;
                p = int'(a) * int'(ca);
                if (!one_mul) p = p + int'(b) * int'(cb);
                t = int'(mid) + floor_div16(p + 8);
                if (t > 511) begin exp_res = 511; exp_ovf = 1; end
                else if (t < -512) begin exp_res = -512; exp_ovf = 1; end
                else begin exp_res = t; exp_ovf = 0; end
                exp_tag = cur_tag;
            end else begin
                exp_tag = "R7";
            end
        end
    end

    task automatic compare(string tag);
        checks++;
        if (int'(res) != exp_res || ovf != exp_ovf || vld != exp_vld) begin
            errors++;
            $display("FAIL %s res/ovf/vld actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     tag, res, ovf, vld, exp_res, exp_ovf, exp_vld);
        end
    endtask

    // compare on every falling edge once running
    bit run_cmp = 0;
    always @(negedge clk) if (run_cmp) compare(exp_tag);

    task automatic apply(input int m, input int av, input int cav,
                         input int bv, input int cbv, input bit single,
                         input string tag);
        mid = 10'(m); a = 10'(av); ca = 6'(cav); b = 10'(bv); cb = 6'(cbv);
        one_mul = single; stb = 1'b1; cur_tag = tag;
        @(negedge clk);
        stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset values
        checks++;
        if (res !== 10'sd0 || ovf !== 1'b0 || vld !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset res/ovf/vld actual=%0d/%0d/%0d expected=0/0/0", res, ovf, vld);
        end
        rst_n = 1'b1;
        @(negedge clk);
        run_cmp = 1;
        apply(10, 20, 16, 30, 16, 0, "R2");        // 60
        apply(100, 1, -8, 0, 0, 0, "R2");          // rounds to 0 -> 100
        apply(100, 1, -9, 0, 0, 0, "R2");          // -1 -> 99
        apply(0, 7, 5, -3, 9, 0, "R2");            // (35-27+8)/16 -> 1
        apply(5, 40, 12, 511, 31, 1, "R3");        // b term excluded
        apply(5, 40, 12, -512, -32, 1, "R3");      // same, different b
        apply(511, 511, 31, 0, 0, 0, "R4");        // clamp high
        apply(-512, -512, 31, 3, 3, 0, "R4");      // clamp low
        apply(0, -512, -32, -512, -32, 0, "R1");   // extreme product sum
        apply(511, 0, 0, 0, 0, 0, "R5");           // upper limit exact
        apply(-512, 3, 2, 0, 0, 0, "R5");          // (6+8)/16 = 0 -> -512
        apply(3, 200, 20, -100, 10, 0, "R6");
        repeat (3) @(negedge clk);                  // idle: R7 hold
        apply(-7, -33, 17, 44, -21, 0, "R6");
        apply(1, 2, 3, 4, 5, 0, "R6");              // back-to-back strobes
        for (int i = 0; i < 400; i++) begin
            int m, av, bv, cav, cbv;
            bit sg;
            m = int'($urandom_range(1023)) - 512;
            av = int'($urandom_range(1023)) - 512;
            bv = int'($urandom_range(1023)) - 512;
            cav = int'($urandom_range(63)) - 32;
            cbv = int'($urandom_range(63)) - 32;
            sg = 1'($urandom_range(1));
            apply(m, av, cav, bv, cbv, sg, sg ? "R3" : "R2");
            if ($urandom_range(3) == 0) @(negedge clk);
        end
        @(negedge clk);
        run_cmp = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule